// File: doc/BRIEF.md
# I2C Command Slave Front End

This block is the serial control port of a small converter-style peripheral. It watches an I2C bus (SCL and an open-drain SDA), finds Start, repeated Start and Stop conditions, and compares the first byte of each transfer with its own 7-bit address. That address is a fixed 5-bit prefix (default `10010`) followed by two bits taken from strap pins. On a matching write it acknowledges every byte. It splits the first byte after the address into a configuration/multiplexer field, a power-down code and a mode bit, and presents them with a one-cycle strobe. On a matching read it shifts out bytes taken from an external holding register until the master answers with a not-acknowledge.

The new power-down code does not act at once. It is held as pending and moves to the active power-down output only when the surrounding logic signals that the current operation is complete.

The protocol engine is a state machine with eight states. IDLE waits for a Start. ADDR shifts in the address byte. ADDR_ACK pulls SDA low for the ninth clock. WR_DATA shifts in a written byte, and WR_ACK acknowledges it. RD_DATA drives a read byte MSB first. RD_ACK samples the master's answer. IGNORE leaves the bus alone.

The transitions are as follows:
- ADDR goes to ADDR_ACK on a match, or to IGNORE on a mismatch, at the eighth falling edge of SCL.
- ADDR_ACK goes to WR_DATA or RD_DATA, chosen by the direction bit, at the falling edge that ends the ack clock.
- WR_DATA and WR_ACK alternate.
- RD_DATA goes to RD_ACK after eight bits. RD_ACK returns to RD_DATA on an acknowledge, or goes to IGNORE on a not-acknowledge.
- A Start from any state enters ADDR, and a Stop from any state enters IDLE.

Top module: `cmd_i2c_slave`

## Requirements
- R1: After reset, sda_oe, cmd_valid, pd_active, cmd_cfg, cmd_pd and cmd_mode are all 0.
- R2: A Start (SDA falling while SCL is high) begins an address phase from any state.
- R3: The address byte is received MSB first. The slave pulls SDA low during the ninth clock only when bits 7..3 equal the prefix 10010 and bits 2..1 equal addr_sel. Bit 0 is the direction: 1 means read, 0 means write.
- R4: On an address mismatch the slave does not acknowledge and leaves SDA released, with no command strobe, until the next Start or Stop.
- R5: A Stop (SDA rising while SCL is high) ends the transfer and SDA is released.
- R6: In a write, each data byte is acknowledged. The first data byte drives cmd_cfg = bits 7..4, cmd_pd = bits 3..2 and cmd_mode = bit 1, and bit 0 is ignored. cmd_valid pulses for exactly one cycle after that byte's ack clock ends, and the fields then hold.
- R7: Further bytes written in the same transfer are acknowledged but change no output and raise no strobe.
- R8: In a read, rd_data is captured when each byte starts (at the falling edge that ends the previous ack clock) and is sent MSB first.
- R9: After the master answers a read byte with a not-acknowledge, the slave drives nothing until the next Start or Stop.
- R10: A repeated Start ends the current transfer and begins a new address phase without a Stop.
- R11: pd_active loads the most recently received power-down code only in a cycle where op_done is high, and otherwise holds its value.
- R12: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock from the bus |
| sda_in | input | 1 | Serial data level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 2 | Strap pins forming address bits 2..1 |
| rd_data | input | 8 | Holding register sent on reads |
| op_done | input | 1 | Current operation complete; promotes pending power-down code |
| cmd_cfg | output | 4 | Configuration / multiplexer select field |
| cmd_pd | output | 2 | Power-down field of the last command |
| cmd_mode | output | 1 | Mode bit of the last command |
| cmd_valid | output | 1 | One-cycle strobe when a command is decoded |
| pd_active | output | 2 | Power-down code currently in effect |

## Verification
The embedded properties check several rules on every cycle:
- the acknowledge state is entered only with the prefix and strap bits in the receive register;
- a Stop is always followed by a released SDA;
- the command strobe never lasts two cycles;
- the active power-down code moves only on op_done;
- SDA drive changes only in the low phase of SCL.

Some behaviour can only be shown by bench scenarios that run whole transactions:
- the decoded field values, and the discarding of trailing bytes;
- MSB-first read data, with the next byte captured at the ack edge;
- silence after a not-acknowledge or a mismatch;
- recovery through a repeated Start.

// File: rtl/cmdslv_pkg.sv
package cmdslv_pkg;
    localparam int BYTE_W    = 8;
    localparam int CFG_W     = 4;
    localparam int PD_W      = 2;
    localparam int FIELD_W   = CFG_W + PD_W + 1;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } bus_state_t;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [PD_W-1:0]  pd;
        logic             mode;
    } cmd_fields_t;
endpackage

// File: rtl/cmdslv_sync.sv
module cmdslv_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic [W-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= '1;
                else        r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= '1;
                else        r <= {r[STAGES-2:0], d};
            end
            assign q = r[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/cmdslv_busmon.sv
module cmdslv_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Bus conditions need SCL high on both samples; data edges under SCL high are Start/Stop.
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cmdslv_fsm.sv
module cmdslv_fsm
    import cmdslv_pkg::*;
#(
    parameter int                    PREFIX_W = 5,
    parameter logic [PREFIX_W-1:0]   PREFIX   = 5'b10010,
    parameter int                    SEL_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               sda_bit,
    input  logic [SEL_W-1:0]   addr_sel,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic               cmd_load,
    output logic [FIELD_W-1:0] cmd_bits
);
    localparam logic [BIT_CNT_W-1:0] CNT_FULL = BIT_CNT_W'(BYTE_W);
    localparam logic [BIT_CNT_W-1:0] CNT_LAST = BIT_CNT_W'(BYTE_W - 1);

    bus_state_t           state;
    bus_state_t           state_n;
    logic [BIT_CNT_W-1:0] cnt;
    logic [BYTE_W-1:0]    shreg;
    logic [BYTE_W-1:0]    txreg;
    logic                 ack_hi;
    logic                 first_done;
    logic                 nack;
    logic                 addr_hit;

    assign addr_hit = (shreg[BYTE_W-1:1] == {PREFIX, addr_sel});
    assign cmd_bits = shreg[BYTE_W-1:1];

    // Next-state selection
    always_comb begin
        state_n = state;
        if (start_det) begin
            state_n = ST_ADDR;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: state_n = state;
                ST_ADDR:     if (scl_fall && cnt == CNT_FULL) state_n = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall && ack_hi) state_n = shreg[0] ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:  if (scl_fall && cnt == CNT_FULL) state_n = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall && ack_hi) state_n = ST_WR_DATA;
                ST_RD_DATA:  if (scl_fall && cnt == CNT_LAST) state_n = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall && ack_hi) state_n = nack ? ST_IGNORE : ST_RD_DATA;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Shift, count and handshake registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            shreg      <= '0;
            txreg      <= '0;
            ack_hi     <= 1'b0;
            first_done <= 1'b0;
            nack       <= 1'b0;
            cmd_load   <= 1'b0;
        end else begin
            cmd_load <= 1'b0;
            if (start_det || stop_det) begin
                cnt        <= '0;
                ack_hi     <= 1'b0;
                first_done <= 1'b0;
                nack       <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WR_DATA: begin
                        if (scl_rise && cnt < CNT_FULL) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_bit};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == CNT_FULL) begin
                            cnt    <= '0;
                            ack_hi <= 1'b0;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_rise) ack_hi <= 1'b1;
                        if (scl_fall && ack_hi) begin
                            ack_hi <= 1'b0;
                            cnt    <= '0;
                            if (shreg[0]) txreg <= rd_data;
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_rise) ack_hi <= 1'b1;
                        if (scl_fall && ack_hi) begin
                            ack_hi <= 1'b0;
                            if (!first_done) begin
                                cmd_load   <= 1'b1;
                                first_done <= 1'b1;
                            end
                        end
                    end
                    ST_RD_DATA: begin
                        if (scl_fall) begin
                            txreg <= {txreg[BYTE_W-2:0], 1'b0};
                            cnt   <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            ack_hi <= 1'b1;
                            nack   <= sda_bit;
                        end
                        if (scl_fall && ack_hi) begin
                            ack_hi <= 1'b0;
                            cnt    <= '0;
                            txreg  <= rd_data;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_DATA:             sda_oe = ~txreg[BYTE_W-1];
            default:                sda_oe = 1'b0;
        endcase
    end

    assert_ack_needs_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> (shreg[BYTE_W-1:1] == {PREFIX, addr_sel}));

    assert_stop_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
endmodule

// File: rtl/cmdslv_cmdout.sv
module cmdslv_cmdout
    import cmdslv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_load,
    input  logic [FIELD_W-1:0] cmd_bits,
    input  logic               op_done,
    output logic [CFG_W-1:0]   cmd_cfg,
    output logic [PD_W-1:0]    cmd_pd,
    output logic               cmd_mode,
    output logic               cmd_valid,
    output logic [PD_W-1:0]    pd_active
);
    cmd_fields_t          fields;
    logic [PD_W-1:0]      pd_pending;

    assign fields = cmd_fields_t'(cmd_bits);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_cfg    <= '0;
            cmd_pd     <= '0;
            cmd_mode   <= 1'b0;
            cmd_valid  <= 1'b0;
            pd_pending <= '0;
            pd_active  <= '0;
        end else begin
            cmd_valid <= cmd_load;
            if (cmd_load) begin
                cmd_cfg    <= fields.cfg;
                cmd_pd     <= fields.pd;
                cmd_mode   <= fields.mode;
                pd_pending <= fields.pd;
            end
            if (op_done) pd_active <= pd_pending;
        end
    end

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_pd_waits_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_done |=> $stable(pd_active));
endmodule

// File: rtl/cmd_i2c_slave.sv
module cmd_i2c_slave
    import cmdslv_pkg::*;
#(
    parameter int                        ADDR_PREFIX_W = 5,
    parameter logic [ADDR_PREFIX_W-1:0]  ADDR_PREFIX   = 5'b10010,
    parameter int                        ADDR_SEL_W    = 2,
    parameter int                        SYNC_STAGES   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_oe,
    input  logic [ADDR_SEL_W-1:0] addr_sel,
    input  logic [BYTE_W-1:0]     rd_data,
    input  logic                  op_done,
    output logic [CFG_W-1:0]      cmd_cfg,
    output logic [PD_W-1:0]       cmd_pd,
    output logic                  cmd_mode,
    output logic                  cmd_valid,
    output logic [PD_W-1:0]       pd_active
);
    logic               scl_s;
    logic               sda_s;
    logic               scl_rise;
    logic               scl_fall;
    logic               start_det;
    logic               stop_det;
    logic               cmd_load;
    logic [FIELD_W-1:0] cmd_bits;

    cmdslv_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     ({scl_s, sda_s})
    );

    cmdslv_busmon u_busmon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cmdslv_fsm #(
        .PREFIX_W (ADDR_PREFIX_W),
        .PREFIX   (ADDR_PREFIX),
        .SEL_W    (ADDR_SEL_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_s),
        .addr_sel  (addr_sel),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .cmd_load  (cmd_load),
        .cmd_bits  (cmd_bits)
    );

    cmdslv_cmdout u_cmdout (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_load  (cmd_load),
        .cmd_bits  (cmd_bits),
        .op_done   (op_done),
        .cmd_cfg   (cmd_cfg),
        .cmd_pd    (cmd_pd),
        .cmd_mode  (cmd_mode),
        .cmd_valid (cmd_valid),
        .pd_active (pd_active)
    );

    assert_sda_low_phase_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);
endmodule

// File: tb/cmd_i2c_slave_bench.sv
module cmd_i2c_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       sda_line;
    logic       sda_oe;
    logic [1:0] addr_sel = 2'b10;
    logic [7:0] rd_data = 8'h00;
    logic       op_done = 1'b0;
    logic [3:0] cmd_cfg;
    logic [1:0] cmd_pd;
    logic       cmd_mode;
    logic       cmd_valid;
    logic [1:0] pd_active;

    int n_chk = 0;
    int n_fail = 0;
    int r12_bad = 0;
    logic prev_oe = 1'b0;
    logic [7:0] exp_q[$];

    assign sda_line = !(m_low || sda_oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_i2c_slave u_cmd_i2c_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .addr_sel  (addr_sel),
        .rd_data   (rd_data),
        .op_done   (op_done),
        .cmd_cfg   (cmd_cfg),
        .cmd_pd    (cmd_pd),
        .cmd_mode  (cmd_mode),
        .cmd_valid (cmd_valid),
        .pd_active (pd_active)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        m_low = 1'b1; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        m_low = 1'b0; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        m_low = !b; tick(Q);
        scl = 1'b1; tick(2*Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        b = sda_line; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic acked);
        logic bv;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(bv);
        acked = !bv;
    endtask

    task automatic rd_byte(output logic [7:0] d);
        logic bv;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(bv);
            d[i] = bv;
        end
    endtask

    // Scoreboard monitor: every command strobe must match the next queued byte.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R7: actual strobe with fields %0h expected none", {cmd_cfg, cmd_pd, cmd_mode});
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                check_eq("R6 command fields", 32'({cmd_cfg, cmd_pd, cmd_mode}), 32'(e[7:1]));
            end
        end
    end

    // R12 monitor at the ports
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && scl) r12_bad++;
        prev_oe = sda_oe;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic       ack;
        logic [7:0] d;

        tick(5);
        // R1 reset state
        check_eq("R1 sda_oe", 32'(sda_oe), 0);
        check_eq("R1 cmd_valid", 32'(cmd_valid), 0);
        check_eq("R1 pd_active", 32'(pd_active), 0);
        check_eq("R1 fields", 32'({cmd_cfg, cmd_pd, cmd_mode}), 0);
        rst_n = 1'b1;
        tick(5);

        // R2 R3 R6 R7: write with command and trailing byte
        bus_start();
        wr_byte(8'h94, ack);
        check_eq("R3 write address ack", 32'(ack), 1);
        exp_q.push_back(8'hA5);
        wr_byte(8'hA5, ack);
        check_eq("R6 command byte ack", 32'(ack), 1);
        wr_byte(8'h3C, ack);
        check_eq("R7 extra byte ack", 32'(ack), 1);
        bus_stop();
        tick(Q);
        check_eq("R5 released after stop", 32'(sda_oe), 0);
        check_eq("R7 fields kept", 32'({cmd_cfg, cmd_pd, cmd_mode}), 32'({4'hA, 2'b01, 1'b0}));

        // R4 strap mismatch
        bus_start();
        wr_byte(8'h92, ack);
        check_eq("R4 mismatch no ack", 32'(ack), 0);
        wr_byte(8'h11, ack);
        check_eq("R4 ignored byte no ack", 32'(ack), 0);
        bus_stop();
        check_eq("R4 fields unchanged", 32'(cmd_cfg), 32'h A);

        // R3 prefix mismatch
        bus_start();
        wr_byte(8'h9C, ack);
        check_eq("R3 wrong prefix no ack", 32'(ack), 0);
        bus_stop();

        // R8 R9: read two bytes, master NACKs the second
        rd_data = 8'h96;
        bus_start();
        wr_byte(8'h95, ack);
        check_eq("R3 read address ack", 32'(ack), 1);
        rd_byte(d);
        check_eq("R8 first read byte", 32'(d), 32'h96);
        rd_data = 8'h4B;
        send_bit(1'b0);
        rd_byte(d);
        check_eq("R8 second read byte", 32'(d), 32'h4B);
        send_bit(1'b1);
        rd_byte(d);
        check_eq("R9 silent after nack", 32'(d), 32'hFF);
        bus_stop();

        // R10: write then repeated start into a read
        rd_data = 8'hC3;
        bus_start();
        wr_byte(8'h94, ack);
        check_eq("R10 first address ack", 32'(ack), 1);
        exp_q.push_back(8'h5E);
        wr_byte(8'h5E, ack);
        check_eq("R6 second command ack", 32'(ack), 1);
        bus_start();
        wr_byte(8'h95, ack);
        check_eq("R10 repeated start address ack", 32'(ack), 1);
        rd_byte(d);
        check_eq("R10 read after repeated start", 32'(d), 32'hC3);
        send_bit(1'b1);
        bus_stop();

        // R10 R4: mismatch then repeated start to own address
        bus_start();
        wr_byte(8'h90, ack);
        check_eq("R4 mismatch before restart", 32'(ack), 0);
        bus_start();
        wr_byte(8'h94, ack);
        check_eq("R10 restart after ignore", 32'(ack), 1);
        bus_stop();

        // R11: power-down promotion
        check_eq("R11 active before done", 32'(pd_active), 0);
        op_done = 1'b1; tick(1); op_done = 1'b0; tick(1);
        check_eq("R11 active after done", 32'(pd_active), 3);
        bus_start();
        exp_q.push_back(8'h28);
        wr_byte(8'h94, ack);
        wr_byte(8'h28, ack);
        bus_stop();
        tick(Q);
        check_eq("R11 active held without done", 32'(pd_active), 3);
        check_eq("R6 third command pd", 32'(cmd_pd), 2);
        op_done = 1'b1; tick(1); op_done = 1'b0; tick(1);
        check_eq("R11 active takes new code", 32'(pd_active), 2);

        tick(Q);
        check_eq("R6 scoreboard drained", 32'(exp_q.size()), 0);
        check_eq("R12 no drive change with SCL high", 32'(r12_bad), 0);
        report();
    end
endmodule